// File: doc/BRIEF.md
# Coded Pulse Divider with Settled Code Changes

The block divides a master clock down to a periodic pulse output. A four-bit code selects the division ratio and the output polarity. A two-bit duty setting selects how much of each period is spent in the active phase. Software or board straps may change the code while the divider is running. The block accepts a new code only after it has held one value for a window whose length depends on that value. It then applies the code exactly at the end of the current output period. A code that is still moving is never applied, and no value it passed through on the way is ever used.

After reset the block runs a start-up hold. The pulse output stays low and the enable flag stays clear until the code has stayed unchanged for a fixed number of master cycles. The divider then starts from the beginning of a period.

A sequencer with three states drives the block. HOLD counts the start-up cycles. RUN is normal operation. ARMED means a settled new code is waiting for the period boundary. The transitions are:
- hold_done: HOLD to RUN.
- code_settled: RUN to ARMED.
- boundary_load: ARMED to RUN, and the code is swapped.
- candidate_lost: ARMED to RUN, because the candidate moved or returned to the active code, and nothing is swapped.

Top module: `coded_pulse_divider`

## Requirements
- R1: After synchronous reset is released with a steady code, pulse_out and out_en stay low, and out_en rises after exactly 500 master cycles whatever the code value.
- R2: A change of code_in during the start-up hold restarts the hold count, so out_en rises 500 cycles (±1) after the last change.
- R3: The output period is 2^(code[2:0]+2) master cycles, which gives 4 to 512.
- R4: The active phase lasts N/4 × q cycles at the start of each period. N is the period and q is 1, 2, 3, 3 for duty 0, 1, 2, 3. The duty value is sampled at each period start.
- R5: When code[3] is 1 the output is inverted: low during the active phase, then high for the rest of the period.
- R6: The first period after start-up begins at its active phase. A non-inverted first pulse therefore has its nominal width. An inverted first high pulse lasts N minus the active length, which is never below N/4.
- R7: After start-up, a new code is taken only after code_in has held it for 16 × (code + 6) consecutive cycles. Before that the old period continues.
- R8: Any change of code_in within the window restarts the window for the newest value. A value that code_in held for less than its own window is never applied.
- R9: A code excursion shorter than its window that returns to the active code leaves the output unchanged.
- R10: A settled code is loaded only at the end of an output period. Every high and low run at the changeover has either the old or the new nominal length, so no runt appears.
- R11: Once out_en is high it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_in | input | 4 | Raw divider code: bits 2..0 select the ratio, bit 3 selects inverted polarity |
| duty_in | input | 2 | Active-phase length setting |
| pulse_out | output | 1 | Divided pulse output |
| out_en | output | 1 | High once the start-up hold has completed |

## Verification
A wrong hold counter moves the rising edge of out_en off cycle 500, and this shows within one start-up interval. A wrong filter window or a missed window restart changes the measured output period too early. It can also let a period of an intermediate ratio appear. Either fault shows within one window plus two old periods after the code change. A swap off the period boundary shows up as a high or low run whose length matches neither the old setting nor the new one, in the first period after the change.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int CODE_W   = 4;
    localparam int SEL_W    = CODE_W - 1;
    localparam int EXP_BASE = 2;
    localparam int DUTY_W   = 2;
    // counter wide enough for the longest period minus one
    localparam int CNT_W    = (1 << SEL_W) - 1 + EXP_BASE;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } seq_state_e;

    // period length in master cycles for a ratio selector
    function automatic logic [CNT_W:0] period_len(input logic [SEL_W-1:0] sel);
        logic [CNT_W:0] n;
        n = '0;
        n[int'(sel) + EXP_BASE] = 1'b1;
        return n;
    endfunction

    // active-phase length: quarter periods, duty 3 saturates at three quarters
    function automatic logic [CNT_W:0] active_len(input logic [CNT_W:0] n,
                                                  input logic [DUTY_W-1:0] duty);
        logic [CNT_W:0] qt;
        logic [CNT_W:0] r;
        qt = n >> 2;
        unique case (duty)
            2'd0:    r = qt;
            2'd1:    r = qt << 1;
            default: r = qt + (qt << 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fdc_code_filter.sv
module fdc_code_filter
    import fdc_pkg::*;
#(
    parameter int WIN_UNIT = 16,
    parameter int WIN_OFFS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] cand_o,
    output logic              chg_o,
    output logic              settled_o
);

    localparam int WIN_MAX = WIN_UNIT * ((1 << CODE_W) - 1 + WIN_OFFS);
    localparam int WIN_W   = $clog2(WIN_MAX + 1);

    logic [CODE_W-1:0] cand_q;
    logic [WIN_W-1:0]  cnt_q;
    logic [WIN_W-1:0]  win_last;

    // window length depends on the candidate value itself
    always_comb begin
        win_last = WIN_W'(WIN_UNIT * (int'(cand_q) + WIN_OFFS) - 1);
    end

    assign chg_o = (code_i != cand_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= code_i;
            cnt_q  <= '0;
        end else if (chg_o) begin
            cand_q <= code_i;
            cnt_q  <= '0;
        end else if (cnt_q != win_last) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cand_o    = cand_q;
    assign settled_o = (cnt_q == win_last);

    // R7: a settled candidate has not moved in the previous cycle
    a_r7_cand_still: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> (cand_q == $past(cand_q)))
        else $error("R7 settled while candidate moving");

endmodule

// File: rtl/fdc_sequencer.sv
module fdc_sequencer
    import fdc_pkg::*;
#(
    parameter int START_CYC = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cand_i,
    input  logic              chg_i,
    input  logic              settled_i,
    input  logic              wrap_i,
    output logic              run_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int              HOLD_W    = $clog2(START_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(START_CYC - 1);

    seq_state_e        st_q, st_d;
    logic [HOLD_W-1:0] hold_q;
    logic [CODE_W-1:0] act_q;

    logic hold_done, code_settled, boundary_load, candidate_lost;

    assign hold_done      = !chg_i && (hold_q == HOLD_LAST);
    assign code_settled   = settled_i && (cand_i != act_q);
    assign candidate_lost = !settled_i || (cand_i == act_q);
    assign boundary_load  = !candidate_lost && wrap_i;

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (hold_done) st_d = ST_RUN;
            ST_RUN:   if (code_settled) st_d = ST_ARMED;
            ST_ARMED: if (candidate_lost || boundary_load) st_d = ST_RUN;
            default:  st_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    // counters and the active code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    hold_q <= chg_i ? '0 : hold_q + 1'b1;
                    if (hold_done) act_q <= cand_i;
                end
                ST_ARMED: if (boundary_load) act_q <= cand_i;
                default: ;
            endcase
        end
    end

    assign run_o  = (st_q != ST_HOLD);
    assign code_o = act_q;

    // R11: enable never drops once set
    a_r11_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o)
        else $error("R11 enable dropped");

    // R8: active code only ever takes the filter's candidate
    a_r8_direct_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> (act_q == $past(cand_i)))
        else $error("R8 active code not the candidate");

    // R10: after start-up a swap happens only on a period wrap
    a_r10_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q) != ST_HOLD) && (act_q != $past(act_q))) |-> $past(wrap_i))
        else $error("R10 swap off boundary");

    // R7: after start-up a swap needs a settled candidate
    a_r7_swap_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q) != ST_HOLD) && (act_q != $past(act_q))) |-> $past(settled_i))
        else $error("R7 swap before window expired");

endmodule

// File: rtl/fdc_period_gen.sv
module fdc_period_gen
    import fdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              wrap_o,
    output logic              out_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W:0]    n_len;
    logic [CNT_W:0]    a_len;
    logic              active;

    always_comb begin
        n_len  = period_len(code_i[SEL_W-1:0]);
        a_len  = active_len(n_len, duty_q);
        active = ({1'b0, cnt_q} < a_len);
    end

    assign wrap_o = en_i && ({1'b0, cnt_q} == (n_len - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (!en_i || wrap_o) begin
            cnt_q  <= '0;
            duty_q <= duty_i;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // polarity bit flips the phase sense
    assign out_o = en_i && (active ^ code_i[CODE_W-1]);

    // R1: no output activity before the hold completes
    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !out_o)
        else $error("R1 output active during hold");

endmodule

// File: rtl/coded_pulse_divider.sv
module coded_pulse_divider
    import fdc_pkg::*;
#(
    parameter int START_CYC = 500,
    parameter int WIN_UNIT  = 16,
    parameter int WIN_OFFS  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [fdc_pkg::CODE_W-1:0] code_in,
    input  logic [fdc_pkg::DUTY_W-1:0] duty_in,
    output logic                       pulse_out,
    output logic                       out_en
);

    logic [CODE_W-1:0] cand;
    logic [CODE_W-1:0] act_code;
    logic              chg, settled, wrap, run;

    fdc_code_filter #(
        .WIN_UNIT (WIN_UNIT),
        .WIN_OFFS (WIN_OFFS)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (code_in),
        .cand_o    (cand),
        .chg_o     (chg),
        .settled_o (settled)
    );

    fdc_sequencer #(
        .START_CYC (START_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_i    (cand),
        .chg_i     (chg),
        .settled_i (settled),
        .wrap_i    (wrap),
        .run_o     (run),
        .code_o    (act_code)
    );

    fdc_period_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run),
        .code_i (act_code),
        .duty_i (duty_in),
        .wrap_o (wrap),
        .out_o  (pulse_out)
    );

    assign out_en = run;

endmodule

// File: tb/coded_pulse_divider_bench.sv
`timescale 1ns/1ps
module coded_pulse_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_in = 4'd0;
    logic [1:0] duty_in = 2'd0;
    logic       pulse_out, out_en;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_err = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    coded_pulse_divider u_coded_pulse_divider (
        .clk (clk), .rst_n (rst_n), .code_in (code_in), .duty_in (duty_in),
        .pulse_out (pulse_out), .out_en (out_en)
    );

    // code, duty, expected high run, expected low run
    localparam int VEC[8][4] = '{
        '{0, 1, 2, 2},   '{2, 0, 4, 12},   '{3, 2, 24, 8},   '{9, 0, 6, 2},
        '{12, 1, 32, 32}, '{3, 3, 24, 8},  '{7, 0, 128, 384}, '{15, 2, 128, 384}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reset, then count cycles until out_en; flag any output activity meanwhile
    task automatic do_reset(input int code, input int duty, output int held, output bit noisy);
        rst_n = 1'b0; code_in = 4'(code); duty_in = 2'(duty);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        held = 0; noisy = 1'b0;
        while (!out_en) begin
            @(negedge clk);
            held++;
            if (!out_en && pulse_out) noisy = 1'b1;
        end
    endtask

    task automatic sync_rise();
        while (pulse_out) @(negedge clk);
        while (!pulse_out) @(negedge clk);
    endtask

    // called with the output just risen; ends with it just risen again
    task automatic meas(output int hi, output int lo);
        hi = 0; lo = 0;
        while (pulse_out)  begin hi++; @(negedge clk); end
        while (!pulse_out) begin lo++; @(negedge clk); end
    endtask

    task automatic watch(input int ok_until, input int t_end, input int oh, input int ol,
                         input int nh, input int nl, input int forbid,
                         output int early, output int runt, output int seen_forbid,
                         output int lh, output int ll);
        int h, l;
        early = 0; runt = 0; seen_forbid = 0; lh = 0; ll = 0;
        sync_rise();
        while (cyc < t_end) begin
            meas(h, l);
            if (cyc < ok_until && (h != oh || l != ol)) early++;
            if (!((h == oh || h == nh) && (l == ol || l == nl))) runt++;
            if (h + l == forbid) seen_forbid++;
            lh = h; ll = l;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int held, held2, h, l, lead, t0, t1, e, r, f, lh, ll;
        bit noisy;

        // R1 reset state and hold length
        @(negedge clk);
        chk(out_en == 1'b0 && pulse_out == 1'b0, "R1 reset outputs", {out_en, pulse_out}, 0);
        do_reset(0, 1, held, noisy);
        chk(held == 500, "R1 hold length code0", held, 500);
        chk(!noisy, "R1 output low during hold", noisy, 0);
        do_reset(7, 0, held2, noisy);
        chk(held2 == held, "R1 hold independent of code", held2, held);

        // R2 change during hold restarts the count
        rst_n = 1'b0; code_in = 4'd2; duty_in = 2'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(out_en == 1'b0, "R2 still holding", out_en, 0);
        code_in = 4'd3;
        held = 0;
        while (!out_en) begin @(negedge clk); held++; end
        chk(held >= 500 && held <= 502, "R2 hold restarted", held, 501);

        // R3/R4/R5 vector table
        foreach (VEC[i]) begin
            do_reset(VEC[i][0], VEC[i][1], held, noisy);
            sync_rise();
            meas(h, l);
            meas(h, l);
            chk(h + l == VEC[i][2] + VEC[i][3], "R3 period", h + l, VEC[i][2] + VEC[i][3]);
            if (VEC[i][0] >= 8)
                chk(h == VEC[i][2], "R5 inverted high run", h, VEC[i][2]);
            else
                chk(h == VEC[i][2], "R4 active high run", h, VEC[i][2]);
        end

        // R6 first pulse after start-up
        do_reset(1, 0, held, noisy);
        lead = 0; while (!pulse_out) begin lead++; @(negedge clk); end
        h = 0; while (pulse_out) begin h++; @(negedge clk); end
        chk(lead == 0, "R6 starts in active phase", lead, 0);
        chk(h == 2, "R6 first normal pulse width", h, 2);
        do_reset(9, 2, held, noisy);
        lead = 0; while (!pulse_out) begin lead++; @(negedge clk); end
        h = 0; while (pulse_out) begin h++; @(negedge clk); end
        chk(lead == 6, "R6 inverted leading low", lead, 6);
        chk(h >= 2, "R6 inverted first pulse at least quarter", h, 2);

        // R7 / R10 switch 0 -> 1 (window 112 cycles)
        do_reset(0, 1, held, noisy);
        repeat (20) @(negedge clk);
        code_in = 4'd1; t0 = cyc;
        watch(t0 + 105, t0 + 160, 2, 2, 4, 4, 0, e, r, f, lh, ll);
        chk(e == 0, "R7 old ratio kept inside window", e, 0);
        chk(r == 0, "R10 no runt at changeover", r, 0);
        chk(lh == 4 && ll == 4, "R7 new ratio after window", lh + ll, 8);

        // R8 restart with newest value, intermediate never applied
        do_reset(0, 1, held, noisy);
        repeat (20) @(negedge clk);
        code_in = 4'd1;
        repeat (80) @(negedge clk);
        code_in = 4'd2; t1 = cyc;
        watch(t1 + 120, t1 + 200, 2, 2, 8, 8, 8, e, r, f, lh, ll);
        chk(f == 0, "R8 intermediate ratio never seen", f, 0);
        chk(e == 0, "R8 window restarted", e, 0);
        chk(r == 0, "R10 clean switch after restart", r, 0);
        chk(lh == 8 && ll == 8, "R8 newest code applied", lh + ll, 16);

        // R9 short excursion has no effect
        do_reset(0, 1, held, noisy);
        repeat (20) @(negedge clk);
        code_in = 4'd5;
        repeat (50) @(negedge clk);
        code_in = 4'd0; t0 = cyc;
        watch(t0 + 300, t0 + 300, 2, 2, 2, 2, 0, e, r, f, lh, ll);
        chk(e == 0, "R9 excursion ignored", e, 0);
        chk(lh == 2 && ll == 2, "R9 ratio unchanged", lh + ll, 4);

        // R11 enable stays high
        chk(out_en == 1'b1, "R11 enable held", out_en, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule